// File: doc/BRIEF.md
# Extended Stack Pointer with Carry-Linked Extension

This block holds the stack pointer of an 8-bit microcontroller core and widens it to a 10-bit stack address. An 8-bit low pointer is joined to a 2-bit extension register. The extension counts only when the low pointer carries or borrows, and only while extended stacking is active. When extended stacking is off, the extension register is still there, but it is plain storage: it never counts and it never shows up in the address.

The core asks for a push, which steps the pointer up before the write. It asks for a pop, which steps the pointer down after the read. The stack address output always shows the current location, with no register delay. Both registers can be read and written through a special-function-register port. Extended stacking is active when the auto-extend input is high and the two-bit memory configuration input is not 11b. The configuration 11b means the on-chip memory is remapped, and that forces extended stacking off.

Top module: `xstk_ptr`

## Requirements
- R1: After reset the low pointer holds 07h, the extension holds 0, and the stack address is 007h.
- R2: A push alone adds 1 to the low pointer (modulo 256). A pop alone subtracts 1. Push and pop in the same cycle leave the pointer unchanged.
- R3: While extended stacking is active, a push with the low pointer at FFh gives a low pointer of 00h and adds 1 to the extension.
- R4: While extended stacking is active, a pop with the low pointer at 00h gives a low pointer of FFh and subtracts 1 from the extension.
- R5: The extension wraps modulo 4: a carry from 3 gives 0, and a borrow from 0 gives 3.
- R6: The stack address is {extension, low pointer} while extended stacking is active, and {00b, low pointer} otherwise. It follows the registers and mode inputs with no delay.
- R7: While extended stacking is inactive, a carry or borrow out of the low pointer leaves the extension unchanged.
- R8: A memory configuration of 11b turns extended stacking off even when auto-extend is high. Any other configuration value leaves auto-extend in control.
- R9: An SFR write to address 81h loads all 8 bits of the low pointer. An SFR write to address 9Bh loads data bits 1:0 into the extension and drops bits 7:2. Both writes work in every mode.
- R10: SFR reads are combinational. Address 81h returns the low pointer. Address 9Bh returns the extension in bits 1:0, with bits 7:2 read as 1. Any other address returns 00h.
- R11: An SFR write to either pointer register cancels a push or pop in the same cycle. The written register takes the written value, and the other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request: step the pointer up |
| pop_i | input | 1 | Pop request: step the pointer down |
| auto_ext_i | input | 1 | Auto-extend enable |
| mem_cfg_i | input | 2 | Internal memory configuration; 11b means remapped |
| sfr_addr_i | input | 8 | SFR address for reads and writes |
| sfr_we_i | input | 1 | SFR write strobe |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data for the addressed register |
| stk_addr_o | output | 10 | Effective stack address |

## Verification
The low pointer appears in the lower byte of the stack address in the same cycle, so a wrong step shows at the address one clock after the push or pop. A wrong extension is seen at once in the upper address bits while extended stacking is active. When extended stacking is inactive, the upper address bits are forced to zero, so the bench reads the extension through the SFR port to catch a count that should not have happened. The wrap tests place the low pointer at FFh and 00h with the extension at 3 and 0. A single step then exercises the carry, the borrow and the modulo-4 wrap together.

// File: rtl/xsp_pkg.sv
package xsp_pkg;
   typedef enum logic [1:0] {
      STEP_HOLD = 2'b00,
      STEP_UP   = 2'b01,
      STEP_DOWN = 2'b10
   } step_e;
endpackage

// File: rtl/xsp_step_dec.sv
module xsp_step_dec
   import xsp_pkg::*;
(
   input  logic  push_i,
   input  logic  pop_i,
   input  logic  wr_hit_i,
   output step_e step_o
);
   // An SFR write to either pointer register cancels the step (R11)
   always_comb begin
      step_o = STEP_HOLD;
      if (!wr_hit_i) begin
         unique case ({push_i, pop_i})
            2'b10:   step_o = STEP_UP;
            2'b01:   step_o = STEP_DOWN;
            default: step_o = STEP_HOLD;
         endcase
      end
   end
endmodule

// File: rtl/xsp_lo_ptr.sv
module xsp_lo_ptr
   import xsp_pkg::*;
#(
   parameter int unsigned       W   = 8,
   parameter logic [W-1:0]      RST = 8'h07
) (
   input  logic         clk,
   input  logic         rst_n,
   input  step_e        step_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] ptr_o,
   output logic         carry_o,
   output logic         borrow_o
);
   logic [W-1:0] ptr_q;

   // Carry and borrow come from the current value and the requested step
   assign carry_o  = (step_i == STEP_UP)   && (ptr_q == {W{1'b1}});
   assign borrow_o = (step_i == STEP_DOWN) && (ptr_q == {W{1'b0}});
   assign ptr_o    = ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= RST;
      end else if (wr_i) begin
         ptr_q <= wdata_i;
      end else begin
         unique case (step_i)
            STEP_UP:   ptr_q <= ptr_q + 1'b1;
            STEP_DOWN: ptr_q <= ptr_q - 1'b1;
            default:   ptr_q <= ptr_q;
         endcase
      end
   end
endmodule

// File: rtl/xsp_ext_reg.sv
module xsp_ext_reg #(
   parameter int unsigned W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active_i,
   input  logic         carry_i,
   input  logic         borrow_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] ext_o
);
   logic [W-1:0] ext_q;

   assign ext_o = ext_q;

   // Counts only when active; otherwise plain storage. Wraps modulo 2**W.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q <= '0;
      end else if (wr_i) begin
         ext_q <= wdata_i;
      end else if (active_i && carry_i) begin
         ext_q <= ext_q + 1'b1;
      end else if (active_i && borrow_i) begin
         ext_q <= ext_q - 1'b1;
      end
   end
endmodule

// File: rtl/xsp_rd_mux.sv
module xsp_rd_mux #(
   parameter int unsigned       DW       = 8,
   parameter int unsigned       AW       = 8,
   parameter int unsigned       LO_W     = 8,
   parameter int unsigned       EXT_W    = 2,
   parameter logic [AW-1:0]     LO_ADDR  = 8'h81,
   parameter logic [AW-1:0]     EXT_ADDR = 8'h9B
) (
   input  logic [AW-1:0]    addr_i,
   input  logic [LO_W-1:0]  lo_i,
   input  logic [EXT_W-1:0] ext_i,
   output logic [DW-1:0]    rdata_o
);
   localparam int unsigned RSVD_W = DW - EXT_W;

   logic [DW-1:0] lo_word;
   logic [DW-1:0] ext_word;

   if (LO_W < DW) begin : g_lo_pad
      assign lo_word = {{(DW - LO_W){1'b0}}, lo_i};
   end else begin : g_lo_full
      assign lo_word = lo_i;
   end

   // Reserved bits above the extension read back as ones
   if (RSVD_W > 0) begin : g_ext_pad
      assign ext_word = {{RSVD_W{1'b1}}, ext_i};
   end else begin : g_ext_full
      assign ext_word = ext_i;
   end

   always_comb begin
      if (addr_i == LO_ADDR)       rdata_o = lo_word;
      else if (addr_i == EXT_ADDR) rdata_o = ext_word;
      else                         rdata_o = '0;
   end
endmodule

// File: rtl/xstk_ptr.sv
module xstk_ptr
   import xsp_pkg::*;
#(
   parameter int unsigned          SP_W      = 8,
   parameter int unsigned          EXT_W     = 2,
   parameter int unsigned          DW        = 8,
   parameter int unsigned          AW        = 8,
   parameter int unsigned          CFG_W     = 2,
   parameter logic [AW-1:0]        LO_ADDR   = 8'h81,
   parameter logic [AW-1:0]        EXT_ADDR  = 8'h9B,
   parameter logic [SP_W-1:0]      SP_RST    = 8'h07,
   parameter logic [CFG_W-1:0]     REMAP_CFG = 2'b11,
   localparam int unsigned         ADDR_W    = SP_W + EXT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic              auto_ext_i,
   input  logic [CFG_W-1:0]  mem_cfg_i,
   input  logic [AW-1:0]     sfr_addr_i,
   input  logic              sfr_we_i,
   input  logic [DW-1:0]     sfr_wdata_i,
   output logic [DW-1:0]     sfr_rdata_o,
   output logic [ADDR_W-1:0] stk_addr_o
);
   if (SP_W > DW) begin : g_bad_sp_w
      $error("xstk_ptr: SP_W must fit in the SFR data width");
   end
   if (EXT_W >= DW || EXT_W == 0) begin : g_bad_ext_w
      $error("xstk_ptr: EXT_W must be 1 to DW-1");
   end
   if (LO_ADDR == EXT_ADDR) begin : g_bad_addr
      $error("xstk_ptr: pointer registers need distinct SFR addresses");
   end

   logic              lo_hit;
   logic              ext_hit;
   logic              ext_active;
   logic              carry;
   logic              borrow;
   step_e             step;
   logic [SP_W-1:0]   sp_q;
   logic [EXT_W-1:0]  ext_q;

   assign lo_hit     = sfr_we_i && (sfr_addr_i == LO_ADDR);
   assign ext_hit    = sfr_we_i && (sfr_addr_i == EXT_ADDR);
   assign ext_active = auto_ext_i && (mem_cfg_i != REMAP_CFG);

   xsp_step_dec i_step (
      .push_i   (push_i),
      .pop_i    (pop_i),
      .wr_hit_i (lo_hit | ext_hit),
      .step_o   (step)
   );

   xsp_lo_ptr #(.W(SP_W), .RST(SP_RST)) i_lo (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_i   (step),
      .wr_i     (lo_hit),
      .wdata_i  (sfr_wdata_i[SP_W-1:0]),
      .ptr_o    (sp_q),
      .carry_o  (carry),
      .borrow_o (borrow)
   );

   xsp_ext_reg #(.W(EXT_W)) i_ext (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (ext_active),
      .carry_i  (carry),
      .borrow_i (borrow),
      .wr_i     (ext_hit),
      .wdata_i  (sfr_wdata_i[EXT_W-1:0]),
      .ext_o    (ext_q)
   );

   xsp_rd_mux #(
      .DW(DW), .AW(AW), .LO_W(SP_W), .EXT_W(EXT_W),
      .LO_ADDR(LO_ADDR), .EXT_ADDR(EXT_ADDR)
   ) i_rd (
      .addr_i  (sfr_addr_i),
      .lo_i    (sp_q),
      .ext_i   (ext_q),
      .rdata_o (sfr_rdata_o)
   );

   assign stk_addr_o = ext_active ? {ext_q, sp_q} : {{EXT_W{1'b0}}, sp_q};
endmodule

// File: rtl/xstk_ptr_chk.sv
module xstk_ptr_chk #(
   parameter int unsigned      SP_W      = 8,
   parameter int unsigned      EXT_W     = 2,
   parameter int unsigned      DW        = 8,
   parameter int unsigned      AW        = 8,
   parameter int unsigned      CFG_W     = 2,
   parameter logic [AW-1:0]    LO_ADDR   = 8'h81,
   parameter logic [AW-1:0]    EXT_ADDR  = 8'h9B,
   parameter logic [CFG_W-1:0] REMAP_CFG = 2'b11,
   localparam int unsigned     ADDR_W    = SP_W + EXT_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_i,
   input logic              pop_i,
   input logic              auto_ext_i,
   input logic [CFG_W-1:0]  mem_cfg_i,
   input logic [AW-1:0]     sfr_addr_i,
   input logic              sfr_we_i,
   input logic [DW-1:0]     sfr_wdata_i,
   input logic [DW-1:0]     sfr_rdata_o,
   input logic [ADDR_W-1:0] stk_addr_o,
   input logic [EXT_W-1:0]  ext_q
);
   logic            act;
   logic            hit;
   logic            ext_wr;
   logic [SP_W-1:0] sp_now;

   assign act    = auto_ext_i && (mem_cfg_i != REMAP_CFG);
   assign ext_wr = sfr_we_i && (sfr_addr_i == EXT_ADDR);
   assign hit    = ext_wr || (sfr_we_i && (sfr_addr_i == LO_ADDR));
   assign sp_now = stk_addr_o[SP_W-1:0];

   AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && !hit) |=> sp_now == SP_W'($past(sp_now) + 1'b1)); // R2
   AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && !hit) |=> sp_now == SP_W'($past(sp_now) - 1'b1)); // R2
   AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && !hit) |=> $stable(sp_now)); // R2
   AST_CARRY_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (act && push_i && !pop_i && !hit && sp_now == {SP_W{1'b1}})
      |=> ext_q == EXT_W'($past(ext_q) + 1'b1)); // R3
   AST_BORROW_DN: assert property (@(posedge clk) disable iff (!rst_n)
      (act && pop_i && !push_i && !hit && sp_now == {SP_W{1'b0}})
      |=> ext_q == EXT_W'($past(ext_q) - 1'b1)); // R4
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !act |-> stk_addr_o[ADDR_W-1:SP_W] == '0); // R6
   AST_EXT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!act && !ext_wr) |=> $stable(ext_q)); // R7
   AST_EXT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_addr_i == EXT_ADDR) |-> (sfr_rdata_o[DW-1:EXT_W] == '1
                                    && sfr_rdata_o[EXT_W-1:0] == ext_q)); // R10
   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_we_i && sfr_addr_i == LO_ADDR)
      |=> sp_now == $past(sfr_wdata_i[SP_W-1:0])); // R11
endmodule

bind xstk_ptr xstk_ptr_chk #(
   .SP_W(SP_W), .EXT_W(EXT_W), .DW(DW), .AW(AW), .CFG_W(CFG_W),
   .LO_ADDR(LO_ADDR), .EXT_ADDR(EXT_ADDR), .REMAP_CFG(REMAP_CFG)
) i_xstk_ptr_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .push_i      (push_i),
   .pop_i       (pop_i),
   .auto_ext_i  (auto_ext_i),
   .mem_cfg_i   (mem_cfg_i),
   .sfr_addr_i  (sfr_addr_i),
   .sfr_we_i    (sfr_we_i),
   .sfr_wdata_i (sfr_wdata_i),
   .sfr_rdata_o (sfr_rdata_o),
   .stk_addr_o  (stk_addr_o),
   .ext_q       (ext_q)
);

// File: tb/test_xstk_ptr.sv
`timescale 1ns/100ps
module test_xstk_ptr;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       push_i = 1'b0;
   logic       pop_i = 1'b0;
   logic       auto_ext_i = 1'b0;
   logic [1:0] mem_cfg_i = 2'b00;
   logic [7:0] sfr_addr_i = 8'h00;
   logic       sfr_we_i = 1'b0;
   logic [7:0] sfr_wdata_i = 8'h00;
   logic [7:0] sfr_rdata_o;
   logic [9:0] stk_addr_o;

   int vecs = 0;
   int errs = 0;

   localparam logic [7:0] A_LO  = 8'h81;
   localparam logic [7:0] A_EXT = 8'h9B;

   always #2.5 clk = ~clk;

   xstk_ptr i_xstk_ptr (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
      .auto_ext_i(auto_ext_i), .mem_cfg_i(mem_cfg_i),
      .sfr_addr_i(sfr_addr_i), .sfr_we_i(sfr_we_i),
      .sfr_wdata_i(sfr_wdata_i), .sfr_rdata_o(sfr_rdata_o),
      .stk_addr_o(stk_addr_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      sfr_addr_i = a;
      #0.2;
      d = sfr_rdata_o;
   endtask

   // SFR write, optionally together with push/pop
   task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic p, input logic q);
      sfr_addr_i = a; sfr_wdata_i = d; sfr_we_i = 1'b1; push_i = p; pop_i = q;
      tick();
      sfr_we_i = 1'b0; push_i = 1'b0; pop_i = 1'b0;
   endtask

   task automatic step(input logic p, input logic q);
      push_i = p; pop_i = q;
      tick();
      push_i = 1'b0; pop_i = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 reset address", stk_addr_o, 10'h007);
      rd(A_LO, d);  chk("R1 reset low pointer", d, 8'h07);
      rd(A_EXT, d); chk("R1/R10 reset extension read", d, 8'hFC);
      rd(8'h90, d); chk("R10 unmapped read", d, 8'h00);
   endtask

   task automatic t_push_pop();
      auto_ext_i = 1'b0; mem_cfg_i = 2'b00;
      step(1, 0); step(1, 0); step(1, 0);
      chk("R2 three pushes", stk_addr_o, 10'h00A);
      step(0, 1);
      chk("R2 pop", stk_addr_o, 10'h009);
      step(1, 1);
      chk("R2 push and pop together", stk_addr_o, 10'h009);
   endtask

   task automatic t_wrap_up();
      auto_ext_i = 1'b1; mem_cfg_i = 2'b00;
      wr(A_LO, 8'hFE, 0, 0); wr(A_EXT, 8'h01, 0, 0);
      chk("R6 active address", stk_addr_o, 10'h1FE);
      step(1, 0);
      chk("R3 push below wrap", stk_addr_o, 10'h1FF);
      step(1, 0);
      chk("R3 carry into extension", stk_addr_o, 10'h200);
   endtask

   task automatic t_wrap_down();
      step(0, 1);
      chk("R4 borrow from extension", stk_addr_o, 10'h1FF);
   endtask

   task automatic t_modulo();
      logic [7:0] d;
      wr(A_EXT, 8'h03, 0, 0); wr(A_LO, 8'hFF, 0, 0);
      step(1, 0);
      chk("R5 carry from 3 wraps to 0", stk_addr_o, 10'h000);
      step(0, 1);
      chk("R5 borrow from 0 wraps to 3", stk_addr_o, 10'h3FF);
      rd(A_EXT, d); chk("R5 extension read", d, 8'hFF);
   endtask

   task automatic t_ext_off();
      logic [7:0] d;
      auto_ext_i = 1'b0;
      wr(A_EXT, 8'hF6, 0, 0); wr(A_LO, 8'hFF, 0, 0);
      chk("R6 inactive address hides extension", stk_addr_o, 10'h0FF);
      rd(A_EXT, d); chk("R9 write drops upper bits", d, 8'hFE);
      step(1, 0);
      chk("R7 inactive carry", stk_addr_o, 10'h000);
      rd(A_EXT, d); chk("R7 extension unchanged on carry", d, 8'hFE);
      step(0, 1);
      rd(A_EXT, d); chk("R7 extension unchanged on borrow", d, 8'hFE);
      auto_ext_i = 1'b1; #0.2;
      chk("R6 enable shows extension at once", stk_addr_o, 10'h2FF);
   endtask

   task automatic t_remap();
      logic [7:0] d;
      auto_ext_i = 1'b1; mem_cfg_i = 2'b11;
      wr(A_EXT, 8'h01, 0, 0); wr(A_LO, 8'hFF, 0, 0);
      chk("R8 remap hides extension", stk_addr_o, 10'h0FF);
      step(1, 0);
      rd(A_EXT, d); chk("R8 remap blocks carry", d, 8'hFD);
      chk("R8 remap address after push", stk_addr_o, 10'h000);
      mem_cfg_i = 2'b10; #0.2;
      chk("R8 other config keeps extension", stk_addr_o, 10'h100);
   endtask

   task automatic t_prio();
      logic [7:0] d;
      mem_cfg_i = 2'b00; auto_ext_i = 1'b1;
      wr(A_LO, 8'h20, 0, 0); wr(A_EXT, 8'h00, 0, 0);
      wr(A_LO, 8'h55, 1, 0);
      chk("R11 low write beats push", stk_addr_o, 10'h055);
      wr(A_EXT, 8'h02, 0, 1);
      chk("R11 extension write cancels pop", stk_addr_o, 10'h255);
      wr(A_LO, 8'hFF, 1, 0);
      chk("R11 no carry on write cycle", stk_addr_o, 10'h2FF);
      rd(A_LO, d); chk("R10 low pointer read", d, 8'hFF);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_push_pop();
      t_wrap_up();
      t_wrap_down();
      t_modulo();
      t_ext_off();
      t_remap();
      t_prio();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule